// File: doc/BRIEF.md
# Table-Backed Bit Store with Shift Mode

This block keeps a small bank of single-bit cells, sixteen by default, and lets the same cells be used in one of two ways. In memory mode the bank behaves as a one-bit-wide RAM. Port A writes and reads at one address. Port B reads at a second address and never writes. Each read port can return data straight from the cells in the same cycle, or through an output flop one cycle later.

In shift mode the same cells form a serial chain. Each enabled clock pushes the input bit into cell 0 and moves every other cell up by one. The port-A address picks which cell drives the serial output, so the chain length can be set anywhere from 1 to the full depth.

Because both uses share one storage array, switching modes keeps the contents. A pattern shifted in can be read back by address, and a pattern written by address can be shifted out.

Top module: `lutram_shreg`

## Requirements
- R1: While `rst_n` is low, every cell is cleared and both read flops hold 0. After reset, every address reads 0 on both ports and `shift_q` is 0.
- R2: In memory mode (`mode_shift`=0) with `wr_en`=1, the rising clock edge stores `din` into the cell at `addr_a`. No other cell changes.
- R3: With `wr_en`=0 no cell changes in either mode, whatever `din` does.
- R4: With `rd_sync`=0, `rdata_a` equals the cell at `addr_a` in the same cycle, following address changes without waiting for a clock.
- R5: With `rd_sync`=0, reading the address that is being written returns the old value until the write edge. The new value appears right after that edge.
- R6: `rdata_b` returns the cell at `addr_b` and is independent of `addr_a`. A write to `addr_a` never changes a different cell that port B is reading.
- R7: With `rd_sync`=1, each read output shows the cell value captured at the previous rising edge, from the address presented then. A write at an edge is therefore seen one edge later.
- R8: In shift mode (`mode_shift`=1) with `wr_en`=1, each rising edge loads cell 0 with `din` and cell i with the old cell i-1.
- R9: In shift mode `shift_q` equals port-A read data, so with `rd_sync`=0 it shows the bit shifted in `addr_a`+1 enabled edges earlier. In memory mode `shift_q` is 0.
- R10: Changing `mode_shift` keeps the contents. After shifting, memory-mode address k reads the bit held in cell k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_shift | input | 1 | 0 = memory mode, 1 = shift mode |
| wr_en | input | 1 | Write enable in memory mode, shift enable in shift mode |
| din | input | 1 | Write data or serial input |
| addr_a | input | 4 | Port-A write/read address, shift tap select |
| addr_b | input | 4 | Port-B read address |
| rd_sync | input | 1 | 0 = asynchronous read, 1 = registered read |
| rdata_a | output | 1 | Port-A read data |
| rdata_b | output | 1 | Port-B read data |
| shift_q | output | 1 | Serial output from the selected tap |

## Verification
The hardest case to reach from the ports is a read of the very cell being written. It has to be seen both in the cycle before the write edge and in the cycle after it, and the asynchronous and registered paths must give different answers there. The bench holds a write pending on one address while it samples `rdata_a` before the edge. In registered mode it watches two consecutive edges on the same address, so that the old value and then the new value must appear in that order. Shift taps are checked against a model chain while the tap address moves at every step.

// File: rtl/lutram_shreg_pkg.sv
package lutram_shreg_pkg;

  typedef enum logic {
    LM_RAM   = 1'b0,
    LM_SHIFT = 1'b1
  } lm_mode_e;

  // Cell update enable: every cell moves in shift mode, only the addressed cell in RAM mode.
  function automatic logic cell_load(lm_mode_e mode, logic we, logic hit);
    return we & ((mode == LM_SHIFT) | hit);
  endfunction

  // Value a cell takes when it loads.
  function automatic logic cell_next(lm_mode_e mode, logic din, logic below);
    return (mode == LM_SHIFT) ? below : din;
  endfunction

endpackage

// File: rtl/lutram_shreg_array.sv
module lutram_shreg_array
  import lutram_shreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lm_mode_e          mode,
  input  logic              wr_en,
  input  logic              din,
  input  logic [ADDR_W-1:0] waddr,
  output logic [DEPTH-1:0]  bits
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic below;
    logic load;
    if (i == 0) begin : g_head
      assign below = din;
    end else begin : g_body
      assign below = bits[i-1];
    end
    assign load = cell_load(mode, wr_en, waddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bits[i] <= 1'b0;
      else if (load) bits[i] <= cell_next(mode, din, below);
    end
  end

endmodule

// File: rtl/lutram_shreg_rdport.sv
module lutram_shreg_rdport #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sync,
  input  logic [DEPTH-1:0]  bits,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rdata
);

  logic comb_bit;
  logic held_bit;

  assign comb_bit = bits[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_bit <= 1'b0;
    else        held_bit <= comb_bit;
  end

  assign rdata = rd_sync ? held_bit : comb_bit;

endmodule

// File: rtl/lutram_shreg.sv
module lutram_shreg
  import lutram_shreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_shift,
  input  logic              wr_en,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              rd_sync,
  output logic              rdata_a,
  output logic              rdata_b,
  output logic              shift_q
);

  lm_mode_e                       mode;
  logic [DEPTH-1:0]               mem_bits;
  logic [NPORT-1:0][ADDR_W-1:0]   port_addr;
  logic [NPORT-1:0]               port_data;

  assign mode         = lm_mode_e'(mode_shift);
  assign port_addr[0] = addr_a;
  assign port_addr[1] = addr_b;

  lutram_shreg_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .wr_en (wr_en),
    .din   (din),
    .waddr (addr_a),
    .bits  (mem_bits)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lutram_shreg_rdport #(.ADDR_W(ADDR_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_sync (rd_sync),
      .bits    (mem_bits),
      .raddr   (port_addr[p]),
      .rdata   (port_data[p])
    );
  end

  assign rdata_a = port_data[0];
  assign rdata_b = port_data[1];
  assign shift_q = (mode == LM_SHIFT) ? port_data[0] : 1'b0;

endmodule

// File: rtl/lutram_shreg_chk.sv
module lutram_shreg_chk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_shift,
  input logic              wr_en,
  input logic              din,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic              rd_sync,
  input logic              rdata_a,
  input logic              rdata_b,
  input logic              shift_q,
  input logic [DEPTH-1:0]  mem_bits
);

  a_r2_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_shift && wr_en) |=> mem_bits[$past(addr_a)] == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_bits));

  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_shift && wr_en) |=> mem_bits == {$past(mem_bits[DEPTH-2:0]), $past(din)});

  a_r4_async_a: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sync |-> rdata_a == mem_bits[addr_a]);

  a_r6_async_b: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sync |-> rdata_b == mem_bits[addr_b]);

  a_r7_sync_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sync |-> rdata_a == $past(mem_bits[addr_a]));

  a_r9_ram_tap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_shift |-> !shift_q);

endmodule

bind lutram_shreg lutram_shreg_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lutram_shreg_tb.sv
module lutram_shreg_tb;

  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_shift = 1'b0, wr_en = 1'b0, din = 1'b0, rd_sync = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic rdata_a, rdata_b, shift_q;

  logic [N-1:0] ref_mem = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lutram_shreg #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_shift(mode_shift), .wr_en(wr_en),
    .din(din), .addr_a(addr_a), .addr_b(addr_b), .rd_sync(rd_sync),
    .rdata_a(rdata_a), .rdata_b(rdata_b), .shift_q(shift_q)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge; inputs change 2 ns after the edge.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      addr_a = AW'(i); addr_b = AW'(N-1-i);
      #1;
      check("R1 port A", rdata_a, 1'b0);
      check("R1 port B", rdata_b, 1'b0);
      check("R1 shift_q", shift_q, 1'b0);
    end
  endtask

  task automatic t_ram_write(logic [N-1:0] pat);
    mode_shift = 1'b0; rd_sync = 1'b0;
    for (int i = 0; i < N; i++) begin
      addr_a = AW'(i); addr_b = AW'(i + N/2);
      din = pat[i]; wr_en = 1'b1;
      #1;
      check("R5 old value before edge", rdata_a, ref_mem[i]);
      check("R6 port B during write", rdata_b, ref_mem[(i + N/2) % N]);
      step();
      ref_mem[i] = pat[i];
      check("R5 new value after edge", rdata_a, pat[i]);
      check("R9 shift_q zero in RAM mode", shift_q, 1'b0);
    end
    wr_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      addr_a = AW'(i); addr_b = AW'(N-1-i);
      #1;
      check("R2/R4 read back A", rdata_a, ref_mem[i]);
      check("R6 read back B", rdata_b, ref_mem[N-1-i]);
    end
  endtask

  task automatic t_hold();
    for (int m = 0; m < 2; m++) begin
      mode_shift = m[0]; wr_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
        din = k[0]; addr_a = AW'(k * 5);
        step();
      end
    end
    mode_shift = 1'b0;
    for (int i = 0; i < N; i++) begin
      addr_a = AW'(i);
      #1;
      check("R3 no change with wr_en low", rdata_a, ref_mem[i]);
    end
  endtask

  task automatic t_sync();
    logic oldv;
    mode_shift = 1'b0; rd_sync = 1'b1; wr_en = 1'b0;
    addr_a = AW'(3); addr_b = AW'(9);
    step();
    check("R7 sync A", rdata_a, ref_mem[3]);
    check("R7 sync B", rdata_b, ref_mem[9]);
    oldv = ref_mem[3];
    din = ~oldv; wr_en = 1'b1;
    step();
    ref_mem[3] = ~oldv;
    wr_en = 1'b0;
    #1;
    check("R7 sync shows old after write edge", rdata_a, oldv);
    step();
    check("R7 sync shows new one edge later", rdata_a, ~oldv);
    addr_a = AW'(10);
    #1;
    check("R7 sync ignores address until edge", rdata_a, ~oldv);
    step();
    check("R7 sync new address", rdata_a, ref_mem[10]);
    rd_sync = 1'b0;
  endtask

  task automatic t_shift();
    logic [31:0] stream = 32'hC36B_1E5D;
    mode_shift = 1'b1; rd_sync = 1'b0;
    for (int s = 0; s < 24; s++) begin
      din = stream[s]; wr_en = 1'b1;
      step();
      ref_mem = {ref_mem[N-2:0], stream[s]};
      addr_a = AW'((s * 7) % N);
      #1;
      check("R8/R9 tap output", shift_q, ref_mem[addr_a]);
      if (s >= int'(addr_a))
        check("R9 delay addr+1", shift_q, stream[s - int'(addr_a)]);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_switch();
    mode_shift = 1'b0;
    for (int i = 0; i < N; i++) begin
      addr_a = AW'(i); addr_b = AW'(i);
      #1;
      check("R10 contents kept A", rdata_a, ref_mem[i]);
      check("R10 contents kept B", rdata_b, ref_mem[i]);
      check("R9 shift_q zero", shift_q, 1'b0);
    end
  endtask

  initial begin
    #1;
    check("R1 reset port A", rdata_a, 1'b0);
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_ram_write(16'hA5C3);
    t_hold();
    t_sync();
    t_shift();
    t_switch();
    t_ram_write(16'h3C96);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule